// File: doc/BRIEF.md
# Four-Decade BCD Up/Down Counter

This block keeps a four-digit decimal count in packed BCD and moves it one step for each rising edge seen on a raw count input. A direction input picks increment or decrement. The count input is brought into the system clock domain through a short synchronizer chain, and its rising edges are found there. Each decade rolls over on its own and passes a step to the next one up, so the count runs from 0000 to 9999 and wraps around at both ends.

Next to the counter there are two holding registers. A display latch takes a copy of the count while an active-low store input is low. A compare register takes a preset value from the parallel BCD data input. Three flags report on the count: a one-cycle pulse when the whole count wraps, a match between count and compare register, and a zero count. The active-low reset clears the counter asynchronously. The same reset also forces the preset path to zero, so a compare-register load made during reset writes 0000. Loads and reset both block counting.

Top module: `bcd_updown_counter4`

## Requirements
- R1: With up_dn high, each rising edge of cnt_in adds one to count_q. The new value appears SYNC_STAGES+1 clock edges after the edge is sampled.
- R2: With up_dn low, each rising edge of cnt_in subtracts one from count_q, with the same latency as R1.
- R3: Digit i of every BCD bus sits at bits 4i+3..4i, with digit 0 least significant. A digit goes from 9 to 0 when counting up and from 0 to 9 when counting down, and that step moves the next digit by one in the same direction.
- R4: cy_bw is high for exactly one clock, in the cycle where count_q first shows a wrap from 9999 to 0000 (counting up) or from 0000 to 9999 (counting down).
- R5: A rising edge of cnt_in has no effect on count_q while rst_n is low or while ld_cnt is high.
- R6: ld_cnt high at a clock edge loads preset_data into the counter.
- R7: ld_reg high at a clock edge loads preset_data into the compare register. If rst_n is low at that edge, the register is loaded with 0000.
- R8: store_n low at a clock edge copies count_q into latch_q. While store_n stays high, latch_q holds its value.
- R9: rst_n low clears count_q to 0000 at once, without waiting for a clock edge.
- R10: equal is high exactly when all four decades of the count match the compare register.
- R11: zero is high exactly when count_q is 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low counter reset; also zeroes the preset path |
| cnt_in | input | 1 | Raw count input, asynchronous to clk |
| up_dn | input | 1 | Direction: 1 counts up, 0 counts down |
| ld_cnt | input | 1 | Load preset_data into the counter; blocks counting |
| ld_reg | input | 1 | Load preset_data (or zero during reset) into the compare register |
| store_n | input | 1 | Active-low store: copy count into the display latch |
| preset_data | input | 16 | Packed BCD preset value |
| count_q | output | 16 | Live packed BCD count |
| latch_q | output | 16 | Display latch contents |
| cy_bw | output | 1 | One-cycle pulse on full-count wrap |
| equal | output | 1 | Count equals compare register |
| zero | output | 1 | Count is 0000 |

## Verification
A decade that fails to pass its step onward shows up at count_q on the clock edge that should have rolled it, three cycles after the input edge. It is caught by the 0099/0100 and 9999/0000 crossings. A compare register or display latch that takes data when it should not shows up through equal or latch_q on the next edge. Reset and load stimulus is therefore followed by count pulses and then read back through those outputs. A carry pulse that lasts too long or comes at the wrong time changes the number of pulses the monitor sees within the cycle after the wrap.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;
   localparam int DIGIT_W = 4;
   typedef logic [DIGIT_W-1:0] bcd_digit_t;
   localparam bcd_digit_t DIGIT_MAX = 4'd9;
   localparam bcd_digit_t DIGIT_MIN = 4'd0;
endpackage

// File: rtl/cnt_edge_sync.sv
module cnt_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   logic [STAGES-1:0] chain;
   logic              last;

   if (STAGES < 2) begin : g_bad_stages
      $error("cnt_edge_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         last  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], din};
         last  <= chain[STAGES-1];
      end
   end

   assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/bcd_decade.sv
module bcd_decade
   import bcd_cnt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       up,
   input  logic       load,
   input  bcd_digit_t ld_val,
   output bcd_digit_t digit,
   output logic       at_limit
);
   bcd_digit_t nxt;

   always_comb begin
      if (up) nxt = (digit >= DIGIT_MAX) ? DIGIT_MIN : digit + 4'd1;
      else    nxt = (digit == DIGIT_MIN) ? DIGIT_MAX : digit - 4'd1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    digit <= DIGIT_MIN;
      else if (load) digit <= ld_val;
      else if (en)   digit <= nxt;
   end

   assign at_limit = up ? (digit == DIGIT_MAX) : (digit == DIGIT_MIN);
endmodule

// File: rtl/bcd_hold_reg.sv
module bcd_hold_reg #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (we) q <= d;
   end
endmodule

// File: rtl/bcd_updown_counter4.sv
module bcd_updown_counter4
   import bcd_cnt_pkg::*;
#(
   parameter int NUM_DECADES = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           cnt_in,
   input  logic                           up_dn,
   input  logic                           ld_cnt,
   input  logic                           ld_reg,
   input  logic                           store_n,
   input  logic [NUM_DECADES*DIGIT_W-1:0] preset_data,
   output logic [NUM_DECADES*DIGIT_W-1:0] count_q,
   output logic [NUM_DECADES*DIGIT_W-1:0] latch_q,
   output logic                           cy_bw,
   output logic                           equal,
   output logic                           zero
);
   localparam int CNT_W = NUM_DECADES * DIGIT_W;

   if (NUM_DECADES < 1) begin : g_bad_decades
      $error("bcd_updown_counter4: NUM_DECADES must be at least 1");
   end

   logic                   rise;
   logic                   step;
   logic [NUM_DECADES:0]   chain_en;
   logic [NUM_DECADES-1:0] lim;
   logic [CNT_W-1:0]       pre_eff;
   logic [CNT_W-1:0]       reg_q;

   cnt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (cnt_in),
      .rise  (rise)
   );

   assign step        = rise & ~ld_cnt;
   assign chain_en[0] = step;

   for (genvar i = 0; i < NUM_DECADES; i++) begin : g_dec
      bcd_decade u_dec (
         .clk      (clk),
         .rst_n    (rst_n),
         .en       (chain_en[i]),
         .up       (up_dn),
         .load     (ld_cnt),
         .ld_val   (preset_data[i*DIGIT_W +: DIGIT_W]),
         .digit    (count_q[i*DIGIT_W +: DIGIT_W]),
         .at_limit (lim[i])
      );
      assign chain_en[i+1] = chain_en[i] & lim[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cy_bw <= 1'b0;
      else        cy_bw <= chain_en[NUM_DECADES];
   end

   assign pre_eff = rst_n ? preset_data : '0;

   bcd_hold_reg #(.W(CNT_W)) u_cmp_reg (
      .clk (clk),
      .we  (ld_reg),
      .d   (pre_eff),
      .q   (reg_q)
   );

   bcd_hold_reg #(.W(CNT_W)) u_disp_latch (
      .clk (clk),
      .we  (~store_n),
      .d   (count_q),
      .q   (latch_q)
   );

   assign equal = (count_q == reg_q);
   assign zero  = (count_q == '0);
endmodule

// File: rtl/bcd_updown_counter4_chk.sv
module bcd_updown_counter4_chk #(
   parameter int CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ld_cnt,
   input logic          ld_reg,
   input logic          store_n,
   input logic [CW-1:0] preset_data,
   input logic [CW-1:0] count_q,
   input logic [CW-1:0] latch_q,
   input logic [CW-1:0] reg_q,
   input logic          cy_bw
);
   localparam logic [CW-1:0] ALL_NINES = {(CW/4){4'h9}};

   // R9: counter reads zero whenever reset is low at an edge
   a_r9_async_clear: assert property (@(posedge clk) !rst_n |-> count_q == '0);

   // R4: wrap pulse lasts one cycle
   a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cy_bw |=> !cy_bw);

   // R4: pulse only with a wrapped count
   a_r4_wrap_value: assert property (@(posedge clk) disable iff (!rst_n)
      cy_bw |-> (count_q == '0 || count_q == ALL_NINES));

   // R6: load wins over counting
   a_r6_load_value: assert property (@(posedge clk) disable iff (!rst_n)
      ld_cnt |=> count_q == $past(preset_data));

   // R7: register load during reset writes zero
   a_r7_reset_reg_zero: assert property (@(posedge clk)
      (!rst_n && ld_reg) |=> reg_q == '0);

   // R8: latch holds while store is high
   a_r8_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      store_n |=> $stable(latch_q));
endmodule

bind bcd_updown_counter4 bcd_updown_counter4_chk #(.CW(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ld_cnt      (ld_cnt),
   .ld_reg      (ld_reg),
   .store_n     (store_n),
   .preset_data (preset_data),
   .count_q     (count_q),
   .latch_q     (latch_q),
   .reg_q       (reg_q),
   .cy_bw       (cy_bw)
);

// File: tb/bcd_updown_counter4_tb.sv
module bcd_updown_counter4_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_in = 1'b0;
   logic        up_dn = 1'b1;
   logic        ld_cnt = 1'b0;
   logic        ld_reg = 1'b0;
   logic        store_n = 1'b1;
   logic [15:0] preset_data = '0;
   logic [15:0] count_q, latch_q;
   logic        cy_bw, equal, zero;

   int checks = 0;
   int fails  = 0;
   int cy_seen = 0;
   bit done = 0;

   int exp_cnt = 0, exp_reg = 0, exp_latch = 0, exp_cy = 0;

   typedef struct {
      string       tag;
      logic [15:0] cnt;
      logic [15:0] lat;
      logic        eq;
      logic        zr;
      int          cy;
   } item_t;

   item_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   bcd_updown_counter4 u_dut (
      .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .up_dn(up_dn),
      .ld_cnt(ld_cnt), .ld_reg(ld_reg), .store_n(store_n),
      .preset_data(preset_data), .count_q(count_q), .latch_q(latch_q),
      .cy_bw(cy_bw), .equal(equal), .zero(zero)
   );

   function automatic logic [15:0] to_bcd(int v);
      return {4'(v / 1000 % 10), 4'(v / 100 % 10), 4'(v / 10 % 10), 4'(v % 10)};
   endfunction

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic push(string tag);
      item_t it;
      it.tag = tag;
      it.cnt = to_bcd(exp_cnt);
      it.lat = to_bcd(exp_latch);
      it.eq  = (exp_cnt == exp_reg);
      it.zr  = (exp_cnt == 0);
      it.cy  = exp_cy;
      sb.push_back(it);
      while (sb.size() != 0) @(negedge clk);
   endtask

   // monitor: counts wrap pulses and compares results
   initial begin
      item_t it;
      forever begin
         @(negedge clk);
         if (cy_bw) cy_seen++;
         if (sb.size() > 0) begin
            it = sb.pop_front();
            check({it.tag, " count"}, int'(count_q), int'(it.cnt));
            check({it.tag, " latch R8"}, int'(latch_q), int'(it.lat));
            check({it.tag, " equal R10"}, int'(equal), int'(it.eq));
            check({it.tag, " zero R11"}, int'(zero), int'(it.zr));
            check({it.tag, " carry R4"}, cy_seen, it.cy);
         end
      end
   end

   task automatic pulse();
      @(negedge clk) cnt_in = 1'b1;
      repeat (4) @(negedge clk);
      cnt_in = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic count_step(string tag);
      pulse();
      if (up_dn) begin
         if (exp_cnt == 9999) begin exp_cnt = 0; exp_cy++; end
         else exp_cnt++;
      end else begin
         if (exp_cnt == 0) begin exp_cnt = 9999; exp_cy++; end
         else exp_cnt--;
      end
      push(tag);
   endtask

   task automatic load_cnt(int v);
      @(negedge clk) preset_data = to_bcd(v); ld_cnt = 1'b1;
      @(negedge clk) ld_cnt = 1'b0;
      exp_cnt = v;
   endtask

   task automatic load_reg(int v);
      @(negedge clk) preset_data = to_bcd(v); ld_reg = 1'b1;
      @(negedge clk) ld_reg = 1'b0;
      exp_reg = v;
   endtask

   task automatic store();
      @(negedge clk) store_n = 1'b0;
      @(negedge clk) store_n = 1'b1;
      exp_latch = exp_cnt;
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      // reset with register load and store active: both take zero (R7, R9)
      ld_reg = 1'b1; store_n = 1'b0; preset_data = 16'h1234;
      repeat (3) @(negedge clk);
      rst_n = 1'b1; ld_reg = 1'b0; store_n = 1'b1;
      push("R7 R9 reset");

      up_dn = 1'b1;
      for (int k = 0; k < 3; k++) count_step("R1 up");
      up_dn = 1'b0;
      count_step("R2 down");

      load_cnt(99);
      push("R6 load");
      up_dn = 1'b1;
      count_step("R3 ripple up");
      up_dn = 1'b0;
      count_step("R3 ripple down");

      load_cnt(9999);
      up_dn = 1'b1;
      count_step("R4 wrap up");
      up_dn = 1'b0;
      count_step("R4 wrap down");

      load_reg(9999);
      push("R7 R10 reg match");
      count_step("R10 mismatch");

      // count edge while the counter is being loaded (R5)
      @(negedge clk) preset_data = to_bcd(1234); ld_cnt = 1'b1;
      pulse();
      ld_cnt = 1'b0;
      exp_cnt = 1234;
      push("R5 load inhibit");

      store();
      push("R8 store");
      up_dn = 1'b1;
      count_step("R8 hold");

      // count edge and register load while reset is low (R5, R7)
      @(negedge clk) rst_n = 1'b0; ld_reg = 1'b1; preset_data = to_bcd(4321);
      pulse();
      ld_reg = 1'b0; rst_n = 1'b1;
      exp_cnt = 0; exp_reg = 0;
      push("R5 R7 reset inhibit");

      // asynchronous clear between edges (R9)
      load_cnt(500);
      push("R6 preload");
      @(negedge clk);
      #(CLK_PERIOD/4) rst_n = 1'b0;
      #1 check("R9 async clear", int'(count_q), 0);
      @(negedge clk) rst_n = 1'b1;
      exp_cnt = 0;
      push("R9 after reset");

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule